// File: doc/BRIEF.md
# Variable-Length Serial Word Shifter

This block is the bit engine of a full-duplex serial port. A frame begins when `start` is taken while the engine is idle. In that cycle it latches a parallel transmit word, a data length, a frame length and a bit-order choice. A separate clock generator then drives two strobes. `sample_stb` captures the input line into the current bit slot. `shift_stb` moves the engine to the next slot and puts that slot's bit on the output line. Every frame sends one word and receives one word; a frame never runs in one direction only.

The data length and the frame length each take values from 1 to 32. When the frame is longer than the data, the extra slots at the end send zero and the bits sampled in them are dropped. At the end of the frame the received bits come out as a right-aligned word with a one-cycle valid pulse. The same bit-order choice governs both the transmit and the receive direction.

Top module: `serial_word_shifter`

## Requirements
- R1: After reset, `busy`, `sdo` and `rx_valid` are 0 and `rx_word` is all zeros.
- R2: `start` is taken only while `busy` is low. `busy` goes high in the cycle after it is taken and stays high until the last slot of the frame has been sampled. A `start` pulse while `busy` is high has no effect.
- R3: `data_len` and `frame_len` are 6-bit counts of bits. A value of 0 acts as 1 and any value above 32 acts as 32. A frame length shorter than the data length is raised to the data length.
- R4: With `order_sel` equal to 1 the word is sent and received LSB first. Every other value (0, 2, 3) gives MSB first, so the first slot carries bit data_len-1.
- R5: Slots at or beyond the data length drive `sdo` to 0, and the bits sampled in them do not enter the received word.
- R6: `sample_stb` captures `sdi` once per slot. `shift_stb` advances to the next slot only after the current slot has been sampled. A shift strobe in the same cycle as an accepted sample, and any repeated strobe, has no effect.
- R7: `rx_valid` is a one-cycle pulse in the cycle after the last slot is sampled. `rx_word` holds the received bits right-aligned, with every bit at or above the data length zero, and keeps that value until the next frame completes.
- R8: The word, lengths and order are latched when `start` is taken. Changes to those inputs during a frame have no effect on that frame.
- R9: `sdo` is 0 whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (taken while idle) |
| tx_word | input | WORD_W | Parallel word to transmit |
| data_len | input | LEN_W | Data bits per frame (1..32) |
| frame_len | input | LEN_W | Bit slots per frame (1..32) |
| order_sel | input | 2 | Bit order: 1 = LSB first, otherwise MSB first |
| shift_stb | input | 1 | Advance to the next bit slot |
| sample_stb | input | 1 | Capture `sdi` into the current slot |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (registered) |
| busy | output | 1 | Frame in progress |
| rx_word | output | WORD_W | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is updated |

## Verification
On every cycle the assertions check the following: the slot index stays inside the frame, the slot never moves before it has been sampled, the completion pulse ends `busy` and lasts one cycle, the output line is quiet while idle, the latched settings stay fixed during a frame, and the received word has no bits above the data length. Only the bench scenarios can show that bits leave and arrive in the right order, that the length clamping and frame extension produce the intended slot counts, that padding slots are really dropped, and that mid-frame input changes and extra `start` pulses leave the result unchanged. For these the bench runs loopback, constant-one and random-line frames under both regular and random strobe patterns.

// File: rtl/sws_pkg.sv
package sws_pkg;
  localparam logic [1:0] ORDER_LSB_CODE = 2'd1;

  typedef enum logic {
    ORD_MSB = 1'b0,
    ORD_LSB = 1'b1
  } bit_order_e;
endpackage

// File: rtl/sws_slot_ctrl.sv
module sws_slot_ctrl #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             sample_stb,
  input  logic             shift_stb,
  input  logic [LEN_W-1:0] flen,
  output logic             busy,
  output logic             start_acc,
  output logic             sample_acc,
  output logic             done,
  output logic             busy_nxt,
  output logic [LEN_W-1:0] slot,
  output logic [LEN_W-1:0] slot_nxt
);
  logic busy_q, smp_q, smp_nxt, shift_acc;
  logic [LEN_W-1:0] slot_q;

  always_comb begin
    start_acc  = start && !busy_q;
    sample_acc = busy_q && sample_stb && !smp_q;
    shift_acc  = busy_q && shift_stb && smp_q;
    done       = sample_acc && (slot_q == flen - LEN_W'(1));
    busy_nxt   = busy_q;
    slot_nxt   = slot_q;
    smp_nxt    = smp_q;
    if (start_acc) begin
      busy_nxt = 1'b1;
      slot_nxt = '0;
      smp_nxt  = 1'b0;
    end else if (sample_acc) begin
      smp_nxt = 1'b1;
      if (done) busy_nxt = 1'b0;
    end else if (shift_acc) begin
      slot_nxt = slot_q + LEN_W'(1);
      smp_nxt  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      smp_q  <= 1'b0;
      slot_q <= '0;
    end else begin
      busy_q <= busy_nxt;
      smp_q  <= smp_nxt;
      slot_q <= slot_nxt;
    end
  end

  assign busy = busy_q;
  assign slot = slot_q;

  p_slot_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (slot_q < flen));
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> busy_q);
  p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy_q);
  p_no_early_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !smp_q) |=> (slot_q == $past(slot_q)));
endmodule

// File: rtl/sws_tx_select.sv
module sws_tx_select #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              active,
  input  logic [WORD_W-1:0] word,
  input  logic [LEN_W-1:0]  dlen,
  input  logic              lsb_first,
  input  logic [LEN_W-1:0]  slot,
  output logic              bit_out
);
  logic [LEN_W-1:0] idx;
  logic             in_data;

  always_comb begin
    in_data = slot < dlen;
    idx     = lsb_first ? slot : (dlen - LEN_W'(1) - slot);
    bit_out = (active && in_data) ? word[idx] : 1'b0;
  end
endmodule

// File: rtl/sws_rx_assemble.sv
module sws_rx_assemble #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic [LEN_W-1:0]  slot,
  input  logic [LEN_W-1:0]  dlen,
  input  logic              lsb_first,
  input  logic              sdi,
  output logic [WORD_W-1:0] acc_nxt
);
  logic [WORD_W-1:0] acc_q;

  always_comb begin
    acc_nxt = acc_q;
    if (take && (slot < dlen)) begin
      if (lsb_first) acc_nxt[slot] = sdi;
      else           acc_nxt = {acc_q[WORD_W-2:0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else              acc_q <= acc_nxt;
  end

  p_acc_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    (!clear && !take) |=> (acc_q == $past(acc_q)));
endmodule

// File: rtl/serial_word_shifter.sv
module serial_word_shifter #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  data_len,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [1:0]        order_sel,
  input  logic              shift_stb,
  input  logic              sample_stb,
  input  logic              sdi,
  output logic              sdo,
  output logic              busy,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  import sws_pkg::*;

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(WORD_W);

  function automatic logic [LEN_W-1:0] fit_len(input logic [LEN_W-1:0] v);
    if (v == '0)         return LEN_W'(1);
    else if (v > MAX_LEN) return MAX_LEN;
    else                  return v;
  endfunction

  logic [LEN_W-1:0]  in_d, in_f, in_f_raw;
  bit_order_e        in_ord;
  logic [WORD_W-1:0] cur_word, sel_word;
  logic [LEN_W-1:0]  cur_d, cur_f, sel_d;
  bit_order_e        cur_ord, sel_ord;
  logic              start_acc, sample_acc, done, busy_nxt, tx_bit;
  logic [LEN_W-1:0]  slot, slot_nxt;
  logic [WORD_W-1:0] acc_nxt;
  logic              sdo_q, rxv_q;
  logic [WORD_W-1:0] rxw_q;

  always_comb begin
    in_d     = fit_len(data_len);
    in_f_raw = fit_len(frame_len);
    in_f     = (in_f_raw < in_d) ? in_d : in_f_raw;
    in_ord   = (order_sel == ORDER_LSB_CODE) ? ORD_LSB : ORD_MSB;
    sel_word = start_acc ? tx_word : cur_word;
    sel_d    = start_acc ? in_d    : cur_d;
    sel_ord  = start_acc ? in_ord  : cur_ord;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_word <= '0;
      cur_d    <= LEN_W'(1);
      cur_f    <= LEN_W'(1);
      cur_ord  <= ORD_MSB;
    end else if (start_acc) begin
      cur_word <= tx_word;
      cur_d    <= in_d;
      cur_f    <= in_f;
      cur_ord  <= in_ord;
    end
  end

  sws_slot_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb),
    .flen       (cur_f),
    .busy       (busy),
    .start_acc  (start_acc),
    .sample_acc (sample_acc),
    .done       (done),
    .busy_nxt   (busy_nxt),
    .slot       (slot),
    .slot_nxt   (slot_nxt)
  );

  sws_tx_select #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_txsel (
    .active    (busy_nxt),
    .word      (sel_word),
    .dlen      (sel_d),
    .lsb_first (sel_ord == ORD_LSB),
    .slot      (slot_nxt),
    .bit_out   (tx_bit)
  );

  sws_rx_assemble #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_rxasm (
    .clk       (clk),
    .rst       (rst),
    .clear     (start_acc),
    .take      (sample_acc),
    .slot      (slot),
    .dlen      (cur_d),
    .lsb_first (cur_ord == ORD_LSB),
    .sdi       (sdi),
    .acc_nxt   (acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_q <= 1'b0;
      rxv_q <= 1'b0;
      rxw_q <= '0;
    end else begin
      sdo_q <= tx_bit;
      rxv_q <= done;
      if (done) rxw_q <= acc_nxt;
    end
  end

  assign sdo      = sdo_q;
  assign rx_valid = rxv_q;
  assign rx_word  = rxw_q;

  p_sdo_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sdo);
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_word >> cur_d) == '0));
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cur_word) && $stable(cur_d) && $stable(cur_f)));
  p_word_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_word) || $past(rst));
endmodule

// File: tb/serial_word_shifter_bench.sv
module serial_word_shifter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] tx_word = '0;
  logic [5:0]  data_len = 6'd8;
  logic [5:0]  frame_len = 6'd8;
  logic [1:0]  order_sel = 2'd0;
  logic        shift_stb = 1'b0;
  logic        sample_stb = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, busy, rx_valid;
  logic [31:0] rx_word;

  int checks = 0;
  int bad = 0;

  always #10 clk = ~clk;

  serial_word_shifter u_serial_word_shifter (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word),
    .data_len(data_len), .frame_len(frame_len), .order_sel(order_sel),
    .shift_stb(shift_stb), .sample_stb(sample_stb), .sdi(sdi),
    .sdo(sdo), .busy(busy), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  // behavioural reference model
  bit          m_busy, m_smp, m_lsb, m_sdo, m_rv;
  int          m_slot, m_d, m_f;
  logic [31:0] m_w;
  longint      m_acc;
  logic [31:0] m_rx;

  function automatic int eff(input int v);
    if (v == 0) return 1;
    if (v > 32) return 32;
    return v;
  endfunction

  always @(posedge clk) begin
    bit rv;
    rv = 1'b0;
    if (rst) begin
      m_busy = 0; m_smp = 0; m_slot = 0; m_acc = 0; m_rx = '0;
      m_d = 1; m_f = 1; m_lsb = 0; m_w = '0;
    end else if (!m_busy) begin
      if (start) begin
        m_w = tx_word; m_d = eff(int'(data_len)); m_f = eff(int'(frame_len));
        if (m_f < m_d) m_f = m_d;
        m_lsb = (order_sel == 2'd1);
        m_busy = 1; m_slot = 0; m_smp = 0; m_acc = 0;
      end
    end else if (sample_stb && !m_smp) begin
      if (m_slot < m_d) begin
        if (m_lsb) m_acc = m_acc | (longint'(sdi) << m_slot);
        else       m_acc = m_acc * 2 + longint'(sdi);
      end
      m_smp = 1;
      if (m_slot == m_f - 1) begin
        m_busy = 0; m_rx = m_acc[31:0]; rv = 1'b1;
      end
    end else if (shift_stb && m_smp) begin
      m_slot++; m_smp = 0;
    end
    m_rv = rv;
    if (m_busy && m_slot < m_d) m_sdo = m_lsb ? m_w[m_slot] : m_w[m_d-1-m_slot];
    else m_sdo = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (!rst) begin
      chk(busy == m_busy, "R2", "busy", 32'(busy), 32'(m_busy));
      chk(sdo == m_sdo, "R4", "sdo", 32'(sdo), 32'(m_sdo));
      chk(rx_valid == m_rv, "R7", "rx_valid", 32'(rx_valid), 32'(m_rv));
      chk(rx_word == m_rx, "R7", "rx_word", rx_word, m_rx);
      if (!busy) chk(sdo == 1'b0, "R9", "idle sdo", 32'(sdo), 32'd0);
    end
  endtask

  // sdi_mode: 0 loopback, 1 constant one, 2 random
  task automatic frame(input logic [31:0] w, input int dl, input int fl,
                       input logic [1:0] ord, input int sdi_mode, input bit rnd,
                       output logic [31:0] got);
    int guard;
    int phase;
    tx_word = w; data_len = 6'(dl); frame_len = 6'(fl); order_sel = ord;
    start = 1'b1;
    tick();
    tx_word = ~w; data_len = 6'(dl + 3); frame_len = 6'd1; order_sel = ~ord;
    guard = 0; phase = 0;
    while (busy && guard < 2000) begin
      start = ($urandom % 4 == 0);
      if (rnd) begin
        sample_stb = ($urandom % 2 == 0);
        shift_stb  = ($urandom % 2 == 0);
      end else begin
        sample_stb = (phase == 0);
        shift_stb  = (phase == 1);
        phase = 1 - phase;
      end
      case (sdi_mode)
        0: sdi = sdo;
        1: sdi = 1'b1;
        default: sdi = 1'($urandom);
      endcase
      tick();
      guard++;
    end
    start = 1'b0; sample_stb = 1'b0; shift_stb = 1'b0;
    chk(guard < 2000, "R6", "frame completes", 32'(guard), 32'd0);
    chk(rx_valid == 1'b1, "R7", "valid at end", 32'(rx_valid), 32'd1);
    got = rx_word;
    tick();
    chk(rx_valid == 1'b0 && rx_word == got, "R7", "hold after pulse", rx_word, got);
  endtask

  function automatic logic [31:0] mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [31:0] got;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy == 0 && sdo == 0 && rx_valid == 0 && rx_word == 0, "R1", "reset state",
        {busy, sdo, rx_valid, 29'd0}, 32'd0);
    tick();

    // R4 loopback MSB first and LSB first, regular strobes
    frame(32'hA5C3_0F96, 16, 16, 2'd0, 0, 1'b0, got);
    chk(got == (32'hA5C3_0F96 & mask(16)), "R4", "msb loopback", got, 32'hA5C3_0F96 & mask(16));
    frame(32'h1234_5678, 12, 12, 2'd1, 0, 1'b0, got);
    chk(got == (32'h1234_5678 & mask(12)), "R4", "lsb loopback", got, 32'h1234_5678 & mask(12));
    frame(32'h0000_00C5, 8, 8, 2'd3, 0, 1'b0, got);
    chk(got == 32'h0000_00C5, "R4", "code 3 is msb", got, 32'hC5);

    // R3 boundaries and clamping
    frame(32'hDEAD_BEEF, 32, 32, 2'd0, 0, 1'b0, got);
    chk(got == 32'hDEAD_BEEF, "R3", "32-bit word", got, 32'hDEAD_BEEF);
    frame(32'h0000_0001, 1, 1, 2'd0, 0, 1'b0, got);
    chk(got == 32'h1, "R3", "1-bit word", got, 32'h1);
    frame(32'hFFFF_FFFF, 0, 0, 2'd0, 1, 1'b0, got);
    chk(got == 32'h1, "R3", "zero length acts as one", got, 32'h1);
    frame(32'hCAFE_F00D, 45, 50, 2'd1, 0, 1'b0, got);
    chk(got == 32'hCAFE_F00D, "R3", "oversize clamps to 32", got, 32'hCAFE_F00D);
    frame(32'h0000_03FF, 10, 3, 2'd0, 1, 1'b0, got);
    chk(got == mask(10), "R3", "short frame raised", got, mask(10));

    // R5 padding slots: constant-one line, extras dropped
    frame(32'h0000_0055, 7, 20, 2'd0, 1, 1'b0, got);
    chk(got == mask(7), "R5", "msb padding dropped", got, mask(7));
    frame(32'h0000_0055, 5, 31, 2'd1, 1, 1'b0, got);
    chk(got == mask(5), "R5", "lsb padding dropped", got, mask(5));
    frame(32'h0000_2C4B, 14, 24, 2'd0, 0, 1'b0, got);
    chk(got == 32'h2C4B, "R5", "padded loopback", got, 32'h2C4B);

    // R6 / R8 random strobes with mid-frame input changes
    for (int i = 0; i < 40; i++) begin
      logic [31:0] w;
      int dl, fl;
      logic [1:0] o;
      w  = $urandom;
      dl = 1 + ($urandom % 32);
      fl = dl + ($urandom % 4);
      o  = 2'($urandom);
      frame(w, dl, fl, o, 0, 1'b1, got);
      chk(got == (w & mask(dl)), "R8", "random loopback", got, w & mask(dl));
    end
    for (int i = 0; i < 20; i++) begin
      frame($urandom, 1 + ($urandom % 32), 32, 2'($urandom), 2, 1'b1, got);
      chk((got & ~mask(m_d)) == 32'd0, "R6", "random line upper zero", got, got & mask(m_d));
    end

    // R2 idle strobes do nothing
    sample_stb = 1'b1; shift_stb = 1'b1;
    repeat (4) tick();
    sample_stb = 1'b0; shift_stb = 1'b0;
    chk(busy == 1'b0 && rx_valid == 1'b0, "R2", "strobes while idle",
        {30'd0, busy, rx_valid}, 32'd0);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule